// File: doc/BRIEF.md
# DDR SDRAM Command Timing Sequencer

This block sits between a memory controller's request logic and the command pins of a four-bank DDR SDRAM. It takes one abstract request at a time over a valid/ready handshake. A request can be activate, read, write, precharge of one bank, precharge of all banks, mode register load, or auto refresh. The block turns it into the chip-select, row-strobe, column-strobe, write-enable, bank and address lines. The command appears on the bus one clock after the handshake completes. Every clock with no accepted request shows a NOP.

The block keeps an open/closed flag and a set of countdown timers for each bank, plus timers shared by all banks. A request that is legal but would break a minimum spacing is held with ready low until all of its constraints are met. A request that is illegal for the current bank state is consumed at once, in the cycle it is offered. It then produces a one-cycle error pulse instead of a command. All spacings are compile-time cycle counts, and the burst length is a parameter.

Top module: `ddr_cmd_sequencer`

## Requirements
- R1: During and after reset, and on every cycle with no accepted request, the bus shows NOP: {cs_n,ras_n,cas_n,we_n}=0111, bank 0, address 0, with err_o low.
- R2: Request op codes are activate 0, read 1, write 2, precharge 3, precharge-all 4, mode register set 5, auto refresh 6. The bus code {cs_n,ras_n,cas_n,we_n} is 0000 for mode set, 0001 for refresh, 0010 for precharge, 0011 for activate, 0100 for write and 0101 for read. A request accepted at a clock edge is on the bus for the following cycle, at most one per clock.
- R3: Activate, read, write and mode set drive the requested bank (0 to 3) on the bank lines. Read and write put the auto-precharge flag on address bit 10 and the column on the other bits.
- R4: Single-bank precharge drives the bank and an all-zero address. Precharge-all drives address 0x400 (bit 10 set) and bank 0.
- R5: A read or write to a bank comes at least T_RCD (3) cycles after that bank's activate.
- R6: Two activates to different banks are at least T_RRD (2) cycles apart. Two activates to the same bank are at least T_RC (9) cycles apart. A precharge comes at least T_RP (3) cycles before the next activate of that bank.
- R7: A precharge of an open bank waits T_RAS (6) cycles after its activate, BL/2+T_WR (4) cycles after a write to it, and BL/2 (2) cycles after a read from it.
- R8: A read comes at least BL/2+T_WTR (3) cycles after any write. Other column commands may be back to back.
- R9: A read or write with auto-precharge closes its bank. Later reads or writes to that bank are rejected. Its next activate comes at least BL/2+T_RP (5) cycles after that command.
- R10: Mode set and refresh are issued only when all banks are closed and every bank's activate spacing has expired. Any command follows a mode set by at least T_MRD (2) cycles and a refresh by at least T_RFC (10) cycles.
- R11: The following requests are taken in the cycle they are offered and cause no command: a read or write to a closed bank, an activate to an open bank, a mode set or refresh with any bank open, and op code 7. For such a request, the next cycle shows NOP with err_o high for exactly that cycle.
- R12: While a legal request waits on a spacing, req_ready_o is low and the bus shows NOP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Command clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request offered |
| req_ready_o | output | 1 | Request taken at this edge |
| req_op_i | input | 3 | Request op code |
| req_bank_i | input | 2 | Target bank, or register select for mode set |
| req_addr_i | input | 12 | Row, column or mode register value |
| req_ap_i | input | 1 | Auto-precharge for read or write |
| cmd_cs_n_o | output | 1 | Chip select, active low |
| cmd_ras_n_o | output | 1 | Row strobe, active low |
| cmd_cas_n_o | output | 1 | Column strobe, active low |
| cmd_we_n_o | output | 1 | Write enable, active low |
| cmd_ba_o | output | 2 | Bank address |
| cmd_addr_o | output | 12 | Address bus |
| err_o | output | 1 | Rejected-request pulse |

## Verification
A wrong bank flag or timer shows at the ports at the next request that touches that bank. An activate or column command then lands on the bus a cycle or more away from its computed spacing, or an error pulse appears where a command belongs, one clock after the handshake. Shared timers that go wrong show up the same way on the first activate after another bank's activate, the first read after a write, or the first command after a mode set or refresh. The bench therefore checks the exact bus cycle of each command against spacings it works out from the requirements, and also checks that ready stays low while a spacing is pending.

// File: rtl/ddr_seq_pkg.sv
`timescale 1ns/1ps
package ddr_seq_pkg;
  typedef enum logic [2:0] {
    OP_ACT  = 3'd0,
    OP_RD   = 3'd1,
    OP_WR   = 3'd2,
    OP_PRE  = 3'd3,
    OP_PREA = 3'd4,
    OP_MRS  = 3'd5,
    OP_REF  = 3'd6
  } req_op_e;

  // {cs_n, ras_n, cas_n, we_n}
  localparam logic [3:0] CMD_MRS = 4'b0000;
  localparam logic [3:0] CMD_REF = 4'b0001;
  localparam logic [3:0] CMD_PRE = 4'b0010;
  localparam logic [3:0] CMD_ACT = 4'b0011;
  localparam logic [3:0] CMD_WR  = 4'b0100;
  localparam logic [3:0] CMD_RD  = 4'b0101;
  localparam logic [3:0] CMD_NOP = 4'b0111;
endpackage

// File: rtl/ddr_down_cnt.sv
`timescale 1ns/1ps
module ddr_down_cnt #(
  parameter int W = 6
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] val_i,
  output logic         zero_o
);
  logic [W-1:0] cnt_q, dec, cnt_d;

  always_comb begin
    dec   = (cnt_q == '0) ? '0 : cnt_q - W'(1);
    // keep the later of the pending and the new deadline
    cnt_d = (load_i && (val_i > dec)) ? val_i : dec;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  assign zero_o = (cnt_q == '0);

  a_r6_cnt_stays_expired: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q == '0 && !load_i) |=> (cnt_q == '0));
  a_r6_cnt_load_takes: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_i && val_i != '0) |=> (cnt_q != '0));
endmodule

// File: rtl/ddr_bank_ctx.sv
`timescale 1ns/1ps
module ddr_bank_ctx #(
  parameter int CNT_W     = 6,
  parameter int T_RCD     = 3,
  parameter int T_RAS     = 6,
  parameter int T_RC      = 9,
  parameter int T_RP      = 3,
  parameter int T_WR      = 2,
  parameter int BURST_CYC = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic act_i,
  input  logic rd_i,
  input  logic wr_i,
  input  logic ap_i,
  input  logic pre_i,
  output logic open_o,
  output logic col_ok_o,
  output logic pre_ok_o,
  output logic act_ok_o
);
  localparam logic [CNT_W-1:0] RCD_V    = CNT_W'(T_RCD - 1);
  localparam logic [CNT_W-1:0] RAS_V    = CNT_W'(T_RAS - 1);
  localparam logic [CNT_W-1:0] WRPRE_V  = CNT_W'(BURST_CYC + T_WR - 1);
  localparam logic [CNT_W-1:0] RDPRE_V  = CNT_W'(BURST_CYC - 1);
  localparam logic [CNT_W-1:0] RC_V     = CNT_W'(T_RC - 1);
  localparam logic [CNT_W-1:0] RP_V     = CNT_W'(T_RP - 1);
  localparam logic [CNT_W-1:0] APACT_V  = CNT_W'(BURST_CYC + T_RP - 1);

  logic open_q;
  logic auto_pre;
  logic pre_load, act_load;
  logic [CNT_W-1:0] pre_val, act_val;

  assign auto_pre = (rd_i | wr_i) & ap_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 open_q <= 1'b0;
    else if (act_i)              open_q <= 1'b1;
    else if (pre_i || auto_pre)  open_q <= 1'b0;
  end
  assign open_o = open_q;

  always_comb begin
    pre_load = act_i | rd_i | wr_i;
    pre_val  = act_i ? RAS_V : (wr_i ? WRPRE_V : RDPRE_V);
    act_load = act_i | pre_i | auto_pre;
    act_val  = act_i ? RC_V : (pre_i ? RP_V : APACT_V);
  end

  ddr_down_cnt #(.W(CNT_W)) i_rcd_cnt (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(act_i), .val_i(RCD_V), .zero_o(col_ok_o));
  ddr_down_cnt #(.W(CNT_W)) i_pre_cnt (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(pre_load), .val_i(pre_val), .zero_o(pre_ok_o));
  ddr_down_cnt #(.W(CNT_W)) i_act_cnt (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(act_load), .val_i(act_val), .zero_o(act_ok_o));

  a_r5_col_needs_open_rcd: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i || wr_i) |-> (open_q && col_ok_o));
  a_r6_act_needs_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    act_i |-> (!open_q && act_ok_o));
  a_r9_ap_closes: assert property (@(posedge clk_i) disable iff (!rst_ni)
    auto_pre |=> !open_q);
  a_r7_pre_after_ras: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pre_i && open_q) |-> pre_ok_o);
endmodule

// File: rtl/ddr_cmd_sequencer.sv
`timescale 1ns/1ps
module ddr_cmd_sequencer
  import ddr_seq_pkg::*;
#(
  parameter int ADDR_W    = 12,
  parameter int AP_BIT    = 10,
  parameter int NUM_BANKS = 4,
  parameter int BL        = 4,
  parameter int T_RCD     = 3,
  parameter int T_RP      = 3,
  parameter int T_RAS     = 6,
  parameter int T_RC      = 9,
  parameter int T_RRD     = 2,
  parameter int T_WR      = 2,
  parameter int T_WTR     = 1,
  parameter int T_MRD     = 2,
  parameter int T_RFC     = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic [2:0]        req_op_i,
  input  logic [1:0]        req_bank_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic              req_ap_i,
  output logic              cmd_cs_n_o,
  output logic              cmd_ras_n_o,
  output logic              cmd_cas_n_o,
  output logic              cmd_we_n_o,
  output logic [1:0]        cmd_ba_o,
  output logic [ADDR_W-1:0] cmd_addr_o,
  output logic              err_o
);
  localparam int BA_W      = $clog2(NUM_BANKS);
  localparam int BURST_CYC = BL / 2;
  localparam int CNT_W     = $clog2(T_RFC + T_RC + T_RAS + BURST_CYC + T_WR + T_WTR
                                    + T_RP + T_MRD + T_RRD + 2);
  localparam logic [CNT_W-1:0] RRD_V = CNT_W'(T_RRD - 1);
  localparam logic [CNT_W-1:0] MRD_V = CNT_W'(T_MRD - 1);
  localparam logic [CNT_W-1:0] RFC_V = CNT_W'(T_RFC - 1);
  localparam logic [CNT_W-1:0] WTR_V = CNT_W'(BURST_CYC + T_WTR - 1);

  req_op_e op;
  logic [BA_W-1:0] bank;
  assign op   = req_op_e'(req_op_i);
  assign bank = BA_W'(req_bank_i);

  logic [NUM_BANKS-1:0] open_v, col_ok_v, pre_ok_v, act_ok_v;
  logic [NUM_BANKS-1:0] act_v, rd_v, wr_v, pre_v;
  logic illegal, eligible, fire, reject;
  logic rrd_ok, quiet_ok, wtr_ok;

  // ---------------- per-bank state
  for (genvar i = 0; i < NUM_BANKS; i++) begin : g_bank
    logic hit;
    assign hit     = (bank == BA_W'(i));
    assign act_v[i] = fire && (op == OP_ACT) && hit;
    assign rd_v[i]  = fire && (op == OP_RD)  && hit;
    assign wr_v[i]  = fire && (op == OP_WR)  && hit;
    assign pre_v[i] = fire && open_v[i] && (((op == OP_PRE) && hit) || (op == OP_PREA));

    ddr_bank_ctx #(
      .CNT_W(CNT_W), .T_RCD(T_RCD), .T_RAS(T_RAS), .T_RC(T_RC),
      .T_RP(T_RP), .T_WR(T_WR), .BURST_CYC(BURST_CYC)
    ) i_ctx (
      .clk_i(clk_i), .rst_ni(rst_ni),
      .act_i(act_v[i]), .rd_i(rd_v[i]), .wr_i(wr_v[i]), .ap_i(req_ap_i), .pre_i(pre_v[i]),
      .open_o(open_v[i]), .col_ok_o(col_ok_v[i]), .pre_ok_o(pre_ok_v[i]), .act_ok_o(act_ok_v[i])
    );
  end

  // ---------------- device-wide spacing
  logic quiet_load;
  logic [CNT_W-1:0] quiet_val;
  assign quiet_load = fire && ((op == OP_MRS) || (op == OP_REF));
  assign quiet_val  = (op == OP_REF) ? RFC_V : MRD_V;

  ddr_down_cnt #(.W(CNT_W)) i_rrd_cnt (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(|act_v), .val_i(RRD_V), .zero_o(rrd_ok));
  ddr_down_cnt #(.W(CNT_W)) i_quiet_cnt (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(quiet_load), .val_i(quiet_val), .zero_o(quiet_ok));
  ddr_down_cnt #(.W(CNT_W)) i_wtr_cnt (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(|wr_v), .val_i(WTR_V), .zero_o(wtr_ok));

  // ---------------- admission
  always_comb begin
    illegal  = 1'b0;
    eligible = 1'b0;
    case (op)
      OP_ACT: begin
        illegal  = open_v[bank];
        eligible = act_ok_v[bank] & rrd_ok & quiet_ok;
      end
      OP_RD: begin
        illegal  = !open_v[bank];
        eligible = col_ok_v[bank] & wtr_ok & quiet_ok;
      end
      OP_WR: begin
        illegal  = !open_v[bank];
        eligible = col_ok_v[bank] & quiet_ok;
      end
      OP_PRE:  eligible = (!open_v[bank] | pre_ok_v[bank]) & quiet_ok;
      OP_PREA: eligible = (&(~open_v | pre_ok_v)) & quiet_ok;
      OP_MRS, OP_REF: begin
        illegal  = |open_v;
        eligible = (&act_ok_v) & quiet_ok;
      end
      default: illegal = 1'b1;
    endcase
  end

  assign req_ready_o = req_valid_i & (illegal | eligible);
  assign fire        = req_ready_o & !illegal;
  assign reject      = req_ready_o & illegal;

  // ---------------- command encoding
  logic [3:0]        cmd_d, cmd_q;
  logic [1:0]        ba_d, ba_q;
  logic [ADDR_W-1:0] addr_d, addr_q, col_addr;

  always_comb begin
    col_addr         = req_addr_i;
    col_addr[AP_BIT] = req_ap_i;
    cmd_d  = CMD_NOP;
    ba_d   = '0;
    addr_d = '0;
    if (fire) begin
      case (op)
        OP_ACT:  begin cmd_d = CMD_ACT; ba_d = req_bank_i; addr_d = req_addr_i; end
        OP_RD:   begin cmd_d = CMD_RD;  ba_d = req_bank_i; addr_d = col_addr;   end
        OP_WR:   begin cmd_d = CMD_WR;  ba_d = req_bank_i; addr_d = col_addr;   end
        OP_PRE:  begin cmd_d = CMD_PRE; ba_d = req_bank_i; end
        OP_PREA: begin cmd_d = CMD_PRE; addr_d[AP_BIT] = 1'b1; end
        OP_MRS:  begin cmd_d = CMD_MRS; ba_d = req_bank_i; addr_d = req_addr_i; end
        OP_REF:  cmd_d = CMD_REF;
        default: cmd_d = CMD_NOP;
      endcase
    end
  end

  logic err_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmd_q  <= CMD_NOP;
      ba_q   <= '0;
      addr_q <= '0;
      err_q  <= 1'b0;
    end else begin
      cmd_q  <= cmd_d;
      ba_q   <= ba_d;
      addr_q <= addr_d;
      err_q  <= reject;
    end
  end

  assign {cmd_cs_n_o, cmd_ras_n_o, cmd_cas_n_o, cmd_we_n_o} = cmd_q;
  assign cmd_ba_o   = ba_q;
  assign cmd_addr_o = addr_q;
  assign err_o      = err_q;

  a_r11_err_on_nop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> (cmd_q == CMD_NOP));
  a_r12_stall_shows_nop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && !req_ready_o) |=> (cmd_q == CMD_NOP && !err_o));
  a_r10_mode_all_closed: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_q == CMD_MRS || cmd_q == CMD_REF) |-> (open_v == '0));
  a_r2_single_activate: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(act_v));
endmodule

// File: tb/test_ddr_cmd_sequencer.sv
`timescale 1ns/1ps
module test_ddr_cmd_sequencer;
  localparam logic [2:0] Q_ACT = 3'd0, Q_RD = 3'd1, Q_WR = 3'd2, Q_PRE = 3'd3,
                         Q_PREA = 3'd4, Q_MRS = 3'd5, Q_REF = 3'd6, Q_BAD = 3'd7;
  localparam logic [3:0] B_MRS = 4'b0000, B_REF = 4'b0001, B_PRE = 4'b0010,
                         B_ACT = 4'b0011, B_WR = 4'b0100, B_RD = 4'b0101, B_NOP = 4'b0111;

  logic clk = 1'b0, rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic        req_valid = 1'b0, req_ready;
  logic [2:0]  req_op = '0;
  logic [1:0]  req_bank = '0;
  logic [11:0] req_addr = '0;
  logic        req_ap = 1'b0;
  logic        cs_n, ras_n, cas_n, we_n, err;
  logic [1:0]  ba;
  logic [11:0] addr;

  ddr_cmd_sequencer i_ddr_cmd_sequencer (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_ready_o(req_ready),
    .req_op_i(req_op), .req_bank_i(req_bank), .req_addr_i(req_addr), .req_ap_i(req_ap),
    .cmd_cs_n_o(cs_n), .cmd_ras_n_o(ras_n), .cmd_cas_n_o(cas_n), .cmd_we_n_o(we_n),
    .cmd_ba_o(ba), .cmd_addr_o(addr), .err_o(err)
  );

  typedef struct {
    logic [3:0]  cmd;
    logic [1:0]  ba;
    logic [11:0] addr;
    logic        err;
    int          cyc;
    string       tag;
  } exp_t;

  exp_t sb[$];
  int cyc = 0;
  int n_cmp = 0, n_bad = 0;
  int last_cyc = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  // monitor: every non-NOP bus cycle or error pulse consumes one expected item
  logic [3:0] mon_cmd;
  exp_t       mon_e;
  always @(negedge clk) begin
    if (rst_n) begin
      mon_cmd = {cs_n, ras_n, cas_n, we_n};
      if (mon_cmd != B_NOP || err) begin
        n_cmp++;
        if (sb.size() == 0) begin
          n_bad++;
          $display("FAIL R2: unexpected bus cmd %b err %b at cycle %0d, expected NOP", mon_cmd, err, cyc);
        end else begin
          mon_e = sb.pop_front();
          if (mon_cmd !== mon_e.cmd || ba !== mon_e.ba || addr !== mon_e.addr ||
              err !== mon_e.err || cyc != mon_e.cyc) begin
            n_bad++;
            $display("FAIL %s: cyc %0d cmd %b ba %0d addr %h err %b, expected cyc %0d cmd %b ba %0d addr %h err %b",
                     mon_e.tag, cyc, mon_cmd, ba, addr, err,
                     mon_e.cyc, mon_e.cmd, mon_e.ba, mon_e.addr, mon_e.err);
          end
        end
      end
    end
  end

  task automatic check_nop(input string tag);
    n_cmp++;
    if ({cs_n, ras_n, cas_n, we_n} !== B_NOP || ba !== 2'd0 || addr !== 12'd0 || err !== 1'b0) begin
      n_bad++;
      $display("FAIL %s: bus %b ba %0d addr %h err %b, expected 0111 ba 0 addr 000 err 0",
               tag, {cs_n, ras_n, cas_n, we_n}, ba, addr, err);
    end
  endtask

  // driver: push the expected bus item, offer the request, return when it is on the bus
  task automatic issue(input logic [2:0] op, input logic [1:0] bank, input logic [11:0] a,
                       input logic ap, input int gap, input logic bad, input string tag);
    exp_t e;
    logic [11:0] col;
    col = a;
    col[10] = ap;
    e.ba = 2'd0; e.addr = 12'd0; e.err = 1'b0; e.cmd = B_NOP;
    if (bad) e.err = 1'b1;
    else begin
      case (op)
        Q_ACT:  begin e.cmd = B_ACT; e.ba = bank; e.addr = a;   end
        Q_RD:   begin e.cmd = B_RD;  e.ba = bank; e.addr = col; end
        Q_WR:   begin e.cmd = B_WR;  e.ba = bank; e.addr = col; end
        Q_PRE:  begin e.cmd = B_PRE; e.ba = bank; end
        Q_PREA: begin e.cmd = B_PRE; e.addr = 12'h400; end
        Q_MRS:  begin e.cmd = B_MRS; e.ba = bank; e.addr = a;   end
        Q_REF:  e.cmd = B_REF;
        default: e.cmd = B_NOP;
      endcase
    end
    e.cyc = last_cyc + gap;
    e.tag = tag;
    sb.push_back(e);
    last_cyc = e.cyc;
    req_valid = 1'b1; req_op = op; req_bank = bank; req_addr = a; req_ap = ap;
    #1;
    if (gap > 1 && !bad) begin
      n_cmp++;
      if (req_ready !== 1'b0) begin
        n_bad++;
        $display("FAIL R12: ready %b while spacing pending (%s), expected 0", req_ready, tag);
      end
    end
    while (req_ready !== 1'b1) begin
      @(negedge clk);
      #1;
    end
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL R12: watchdog expired at cycle %0d, expected end before 20000", cyc);
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    check_nop("R1 in reset");
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check_nop("R1 after reset");
    last_cyc = cyc;
    issue(Q_MRS, 2'd0, 12'h032, 1'b0, 1,  1'b0, "R2 mode set");
    issue(Q_MRS, 2'd1, 12'h000, 1'b0, 2,  1'b0, "R10 mode set spacing");
    issue(Q_REF, 2'd0, 12'h000, 1'b0, 2,  1'b0, "R10 refresh after mode set");
    issue(Q_ACT, 2'd0, 12'h123, 1'b0, 10, 1'b0, "R10 refresh spacing");
    issue(Q_ACT, 2'd1, 12'h045, 1'b0, 2,  1'b0, "R6 activate other bank");
    issue(Q_RD,  2'd0, 12'h010, 1'b0, 1,  1'b0, "R5 read bank0");
    issue(Q_RD,  2'd1, 12'h020, 1'b0, 2,  1'b0, "R5 read bank1");
    issue(Q_WR,  2'd0, 12'h030, 1'b0, 1,  1'b0, "R8 write back to back");
    issue(Q_RD,  2'd1, 12'h008, 1'b0, 3,  1'b0, "R8 write to read");
    issue(Q_PRE, 2'd0, 12'hFFF, 1'b0, 1,  1'b0, "R7 write recovery");
    issue(Q_ACT, 2'd0, 12'h200, 1'b0, 3,  1'b0, "R6 precharge to activate");
    issue(Q_WR,  2'd1, 12'h011, 1'b1, 1,  1'b0, "R9 write auto-precharge R3");
    issue(Q_RD,  2'd1, 12'h000, 1'b0, 1,  1'b1, "R9 read closed bank R11");
    issue(Q_RD,  2'd0, 12'h044, 1'b0, 2,  1'b0, "R8 write to read cross bank");
    issue(Q_ACT, 2'd1, 12'h0AA, 1'b0, 2,  1'b0, "R9 activate after auto-precharge");
    issue(Q_ACT, 2'd1, 12'h0AB, 1'b0, 1,  1'b1, "R11 activate open bank");
    issue(Q_PREA,2'd3, 12'h000, 1'b0, 5,  1'b0, "R4 precharge all R7");
    issue(Q_MRS, 2'd0, 12'h022, 1'b0, 3,  1'b0, "R10 mode set after precharge R6");
    issue(Q_ACT, 2'd2, 12'h3FF, 1'b0, 2,  1'b0, "R10 mode set to activate R3");
    issue(Q_REF, 2'd0, 12'h000, 1'b0, 1,  1'b1, "R11 refresh with open bank");
    issue(Q_BAD, 2'd0, 12'h000, 1'b0, 1,  1'b1, "R11 unknown op");
    issue(Q_ACT, 2'd3, 12'h001, 1'b0, 1,  1'b0, "R6 activate bank3");
    issue(Q_PRE, 2'd3, 12'h000, 1'b0, 6,  1'b0, "R7 activate to precharge");
    issue(Q_PRE, 2'd2, 12'h000, 1'b0, 1,  1'b0, "R4 precharge bank2");
    issue(Q_PRE, 2'd3, 12'h000, 1'b0, 1,  1'b0, "R4 precharge closed bank");
    repeat (12) @(negedge clk);
    check_nop("R1 idle");
    @(negedge clk);
    check_nop("R1 idle");
    n_cmp++;
    if (sb.size() != 0) begin
      n_bad++;
      $display("FAIL R2: %0d expected commands never seen, expected 0", sb.size());
    end
    summary();
  end
endmodule